// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a 1 Kbit serial EEPROM that answers a host over three wires: a chip select, a serial clock and a serial data input, plus a serial data output that comes with its own output-enable. A strap input chooses between two views of the same storage: 64 words of 16 bits or 128 words of 8 bits. The storage is a register array inside the model. All pins are sampled on a system clock, and edges of the serial clock and chip select are found by comparing each sample with the one before it.

The host sends a start bit, a two-bit opcode and an address, and then data for writes. Reads stream words out with address auto-increment for as long as chip select stays high. Erase, write, erase-all and write-all change the array only when chip select falls after a complete instruction, and only if an enable instruction has set the write-enable latch. Each program operation then runs a self-timed cycle whose length is a parameter in system clocks. While that cycle runs, raising chip select shows busy (low) and then ready (high) on the data output.

Top module: `w3e_top`

## Requirements
- R1: An instruction is a 1 start bit, a 2-bit opcode and an address of 6 bits when `org_wide` is 1 or 7 bits when it is 0, all sent MSB first and sampled on serial clock rising edges while `cs` is high. Zero bits before the start bit are ignored.
- R2: Opcode 10 reads, 11 erases and 01 writes. With opcode 00, the two most significant address bits choose the operation: 11 sets the write-enable latch, 00 clears it, 10 erases all words and 01 writes all words.
- R3: A read drives a 0 dummy bit after the last address bit and then the data word MSB first. Each bit changes on a serial clock rising edge. Reads work whatever the state of the latch.
- R4: After the last bit of a word has been read, the address advances by one and the next word follows with no new command. The address wraps from the last word to word 0 while `cs` stays high.
- R5: Program operations take effect only on the falling edge of `cs` after the complete instruction, including its data. An instruction cut short by `cs` going low has no effect and starts no cycle.
- R6: Reset clears the write-enable latch. Erase, write, erase-all and write-all with the latch clear change nothing and start no cycle. The latch stays in its state until the next enable or disable instruction.
- R7: Erase sets the addressed unit to all ones. Write replaces the unit with no erase needed first. Erase-all sets every cell to one. Write-all puts the data into every unit.
- R8: While `cs` is high during a program cycle, `sdo_oe` is 1 and `sdo` is 0 for `PROG_CYCLES` system clocks. After the cycle `sdo` is 1 until the next start bit. While `cs` is low, `sdo_oe` is 0.
- R9: Every bit received while a program cycle runs is ignored.
- R10: In the 8-bit view, byte address A selects word A>>1. Bits 15:8 of that word are used when A[0] is 0, and bits 7:0 when A[0] is 1.
- R11: After reset every cell reads as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| org_wide | input | 1 | 1: 64 x 16 organization, 0: 128 x 8 |
| sdo | output | 1 | Serial data / busy-ready status, 0 when not driven |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The write-enable gate and the busy gate both decide at the same chip-select falling edge whether a program operation goes ahead. The bench provokes the conflict by clocking a complete second write into the part while the first cycle is still running and then deselecting, which is a valid-looking commit edge that arrives during busy. This is judged by reading both addresses back after ready: the first holds its new data and the second is unchanged. A separate deselect in the middle of the data field checks that a partial frame never reaches the commit decision.

// File: rtl/w3e_pkg.sv
package w3e_pkg;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_WORDS  = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_DONE
    } rx_state_e;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_ENABLE,
        PEND_DISABLE,
        PEND_ERASE,
        PEND_WRITE,
        PEND_ERASE_ALL,
        PEND_WRITE_ALL
    } pend_e;

    function automatic logic is_program(pend_e k);
        return (k == PEND_ERASE) || (k == PEND_WRITE) ||
               (k == PEND_ERASE_ALL) || (k == PEND_WRITE_ALL);
    endfunction

endpackage

// File: rtl/w3e_timer.sv
module w3e_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (go)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/w3e_mem.sv
module w3e_mem
    import w3e_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int WORDS  = DEF_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  pend_e             kind,
    input  logic              wide,
    input  logic [$clog2(WORDS):0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int WORD_AW = $clog2(WORDS);
    localparam int BYTE_W  = WORD_W / 2;

    logic [WORD_W-1:0]  cells [WORDS];
    logic [WORD_AW-1:0] widx;
    logic [WORD_W-1:0]  src, cur, merged;

    // unit address to word index: 8-bit view uses the upper address bits
    assign widx = wide ? addr[WORD_AW-1:0] : addr[WORD_AW:1];
    assign cur  = cells[widx];
    assign src  = (kind == PEND_ERASE) ? '1 : wdata;

    always_comb begin
        if (wide)
            merged = src;
        else if (addr[0])
            merged = {cur[WORD_W-1:BYTE_W], src[BYTE_W-1:0]};
        else
            merged = {src[BYTE_W-1:0], cur[BYTE_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                cells[i] <= '1;
        end else if (go) begin
            for (int i = 0; i < WORDS; i++) begin
                case (kind)
                    PEND_ERASE_ALL: cells[i] <= '1;
                    PEND_WRITE_ALL: cells[i] <= wide ? wdata
                                              : {2{wdata[BYTE_W-1:0]}};
                    PEND_ERASE, PEND_WRITE:
                        if (WORD_AW'(i) == widx) cells[i] <= merged;
                    default: ;
                endcase
            end
        end
    end

    // read port: unit data right-aligned, upper byte first in 8-bit view
    always_comb begin
        if (wide)
            rdata = cur;
        else if (addr[0])
            rdata = {{BYTE_W{1'b0}}, cur[BYTE_W-1:0]};
        else
            rdata = {{BYTE_W{1'b0}}, cur[WORD_W-1:BYTE_W]};
    end
endmodule

// File: rtl/w3e_serial.sv
module w3e_serial
    import w3e_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs,
    input  logic               sk,
    input  logic               di,
    input  logic               wide,
    input  logic               busy,
    input  logic [WORD_W-1:0]  rd_unit,
    output logic [WORD_AW:0]   unit_addr,
    output logic [WORD_W-1:0]  wr_data,
    output pend_e              pend_kind,
    output logic               prog_go,
    output logic               wel,
    output logic               reading,
    output logic               status_on,
    output logic               rd_bit
);
    localparam int UNIT_AW = WORD_AW + 1;
    localparam int CMD_MAX = 2 + UNIT_AW;
    localparam int CNT_W   = $clog2(WORD_W + CMD_MAX);
    localparam int IW      = $clog2(WORD_W);

    rx_state_e          st;
    logic               cs_q, sk_q, rise, cs_fall;
    logic [CNT_W-1:0]   cnt, cmd_last, data_last;
    logic [CMD_MAX-2:0] sr;
    logic [CMD_MAX-1:0] full;
    logic [1:0]         opc, sel2;
    logic [UNIT_AW-1:0] a_in, next_addr;
    logic [IW-1:0]      bit_idx;

    assign rise    = cs & sk & ~sk_q;
    assign cs_fall = cs_q & ~cs;
    assign full    = {sr, di};

    // field split depends on the organization strap
    assign opc  = wide ? full[CMD_MAX-2 -: 2] : full[CMD_MAX-1 -: 2];
    assign sel2 = wide ? full[WORD_AW-1 -: 2] : full[UNIT_AW-1 -: 2];
    assign a_in = wide ? {1'b0, full[WORD_AW-1:0]} : full[UNIT_AW-1:0];

    assign cmd_last  = wide ? CNT_W'(CMD_MAX - 2) : CNT_W'(CMD_MAX - 1);
    assign data_last = wide ? CNT_W'(WORD_W - 1) : CNT_W'(WORD_W / 2 - 1);
    assign bit_idx   = IW'(data_last - cnt);
    assign next_addr = wide ? {1'b0, unit_addr[WORD_AW-1:0] + 1'b1}
                            : unit_addr + 1'b1;

    assign prog_go = cs_fall && (st == ST_DONE) && is_program(pend_kind)
                     && wel && !busy;
    assign reading = (st == ST_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cs_q      <= 1'b0;
            sk_q      <= 1'b0;
            cnt       <= '0;
            sr        <= '0;
            unit_addr <= '0;
            wr_data   <= '0;
            pend_kind <= PEND_NONE;
            wel       <= 1'b0;
            status_on <= 1'b0;
            rd_bit    <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
            if (!cs) begin
                st <= ST_IDLE;
                if (cs_fall && st == ST_DONE && !busy) begin
                    if (pend_kind == PEND_ENABLE)  wel <= 1'b1;
                    if (pend_kind == PEND_DISABLE) wel <= 1'b0;
                end
                if (prog_go) status_on <= 1'b1;
            end else if (rise) begin
                case (st)
                    ST_IDLE: if (!busy && di) begin
                        st        <= ST_CMD;
                        cnt       <= '0;
                        status_on <= 1'b0;
                        pend_kind <= PEND_NONE;
                    end
                    ST_CMD: begin
                        sr  <= full[CMD_MAX-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == cmd_last) begin
                            cnt       <= '0;
                            unit_addr <= a_in;
                            case (opc)
                                2'b10: begin st <= ST_READ; rd_bit <= 1'b0; end
                                2'b11: begin st <= ST_DONE; pend_kind <= PEND_ERASE; end
                                2'b01: begin st <= ST_DATA; pend_kind <= PEND_WRITE; end
                                default: case (sel2)
                                    2'b11: begin st <= ST_DONE; pend_kind <= PEND_ENABLE; end
                                    2'b00: begin st <= ST_DONE; pend_kind <= PEND_DISABLE; end
                                    2'b10: begin st <= ST_DONE; pend_kind <= PEND_ERASE_ALL; end
                                    default: begin st <= ST_DATA; pend_kind <= PEND_WRITE_ALL; end
                                endcase
                            endcase
                        end
                    end
                    ST_DATA: begin
                        wr_data <= {wr_data[WORD_W-2:0], di};
                        cnt     <= cnt + 1'b1;
                        if (cnt == data_last) st <= ST_DONE;
                    end
                    ST_READ: begin
                        rd_bit <= rd_unit[bit_idx];
                        if (cnt == data_last) begin
                            cnt       <= '0;
                            unit_addr <= next_addr;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/w3e_top.sv
module w3e_top
    import w3e_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int WORDS       = DEF_WORDS,
    parameter int PROG_CYCLES = 250000   // 5 ms at a 50 MHz system clock
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org_wide,
    output logic sdo,
    output logic sdo_oe
);
    localparam int WORD_AW = $clog2(WORDS);

    logic [WORD_AW:0]  unit_addr;
    logic [WORD_W-1:0] wr_data, rd_unit;
    pend_e             pend_kind;
    logic              prog_go, wel, reading, status_on, rd_bit, busy;

    w3e_serial #(.WORD_W(WORD_W), .WORD_AW(WORD_AW)) u_serial (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .wide(org_wide),
        .busy(busy), .rd_unit(rd_unit), .unit_addr(unit_addr),
        .wr_data(wr_data), .pend_kind(pend_kind), .prog_go(prog_go),
        .wel(wel), .reading(reading), .status_on(status_on), .rd_bit(rd_bit)
    );

    w3e_mem #(.WORD_W(WORD_W), .WORDS(WORDS)) u_mem (
        .clk(clk), .rst(rst), .go(prog_go), .kind(pend_kind),
        .wide(org_wide), .addr(unit_addr), .wdata(wr_data), .rdata(rd_unit)
    );

    w3e_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(prog_go), .busy(busy)
    );

    assign sdo_oe = cs & (reading | status_on);
    assign sdo    = sdo_oe & (reading ? rd_bit : ~busy);
endmodule

// File: rtl/w3e_chk.sv
module w3e_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sdo,
    input logic sdo_oe,
    input logic busy,
    input logic wel
);
    // R8: output released whenever the part is deselected
    a_r8_release_when_deselected: assert property (
        @(posedge clk) disable iff (rst) !cs |-> !sdo_oe);

    // R8: a running cycle reads as a driven low
    a_r8_busy_drives_low: assert property (
        @(posedge clk) disable iff (rst) (cs && busy) |-> (sdo_oe && !sdo));

    // R5: a cycle begins only right after a chip-select falling edge
    a_r5_cycle_from_deselect: assert property (
        @(posedge clk) disable iff (rst) $rose(busy) |-> ($past(cs, 2) && !$past(cs)));

    // R6: no cycle without the write-enable latch
    a_r6_cycle_needs_latch: assert property (
        @(posedge clk) disable iff (rst) $rose(busy) |-> $past(wel));

    // R6: the latch moves only at deselect
    a_r6_latch_moves_on_deselect: assert property (
        @(posedge clk) disable iff (rst) !$stable(wel) |-> !$past(cs));
endmodule

bind w3e_top w3e_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .wel(wel)
);

// File: tb/tb_w3e_top.sv
module tb_w3e_top;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst, cs, sk, di, org_wide;
    logic sdo, sdo_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int ref16 [64];
    bit m_wel;

    always #10 clk = ~clk;

    w3e_top #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
        .org_wide(org_wide), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_unit(input bit w, input int a);
        if (w) return ref16[a];
        if (a % 2 == 0) return (ref16[a/2] >> 8) & 'hFF;
        return ref16[a/2] & 'hFF;
    endfunction

    task automatic m_apply(input bit w, input int op, input int sel,
                           input int a, input int d);
        int val, wi;
        if (op == 3 || op == 1) begin
            val = (op == 3) ? 'hFFFF : d;
            if (w) ref16[a] = val & 'hFFFF;
            else begin
                wi = a / 2;
                if (a % 2 == 1) ref16[wi] = (ref16[wi] & 'hFF00) | (val & 'hFF);
                else            ref16[wi] = (ref16[wi] & 'hFF) | ((val & 'hFF) << 8);
            end
        end else if (sel == 2) begin
            for (int i = 0; i < 64; i++) ref16[i] = 'hFFFF;
        end else if (sel == 1) begin
            for (int i = 0; i < 64; i++)
                ref16[i] = w ? (d & 'hFFFF) : (((d & 'hFF) << 8) | (d & 'hFF));
        end
    endtask

    task automatic pulse(input logic b, output logic o);
        di = b;
        @(negedge clk); @(negedge clk);
        sk = 1'b1;
        @(negedge clk); @(negedge clk);
        o  = sdo;
        sk = 1'b0;
    endtask

    task automatic send(input int v, input int n, output logic o);
        for (int i = n - 1; i >= 0; i--) pulse(v[i], o);
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1'b1; @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk); cs = 1'b0; di = 1'b0; @(negedge clk); @(negedge clk);
    endtask

    task automatic read_seq(input bit w, input int a, input int n,
                            input int lead, input string req);
        logic o;
        int ub, aw, depth, got, exp;
        ub = w ? 16 : 8; aw = w ? 6 : 7; depth = w ? 64 : 128;
        org_wide = w;
        cs_on();
        for (int i = 0; i < lead; i++) pulse(1'b0, o);
        send(1, 1, o); send(2, 2, o); send(a, aw, o);
        check(o == 1'b0 && sdo_oe == 1'b1, "R3", "dummy bit then driven",
              int'({o, sdo_oe}), 1);
        for (int k = 0; k < n; k++) begin
            got = 0;
            for (int j = 0; j < ub; j++) begin
                pulse(1'b0, o);
                got = (got << 1) | int'(o);
            end
            exp = model_unit(w, (a + k) % depth);
            check(got == exp, req, "read unit", got, exp);
        end
        cs_off();
    endtask

    task automatic prog(input bit w, input int op, input int a, input int d,
                        input string req);
        logic o;
        int aw, ub, sel;
        bit has_d, cyc;
        aw = w ? 6 : 7; ub = w ? 16 : 8;
        sel = (a >> (aw - 2)) & 3;
        has_d = (op == 1) || (op == 0 && sel == 1);
        cyc = m_wel && !(op == 0 && (sel == 3 || sel == 0));
        org_wide = w;
        cs_on();
        send(1, 1, o); send(op, 2, o); send(a, aw, o);
        if (has_d) send(d, ub, o);
        cs_off();
        if (op == 0 && sel == 3) m_wel = 1'b1;
        if (op == 0 && sel == 0) m_wel = 1'b0;
        if (cyc) m_apply(w, op, sel, a, d);
        cs_on();
        if (cyc) begin
            check(sdo_oe && !sdo, req, "busy shows low", int'({sdo_oe, sdo}), 2);
            repeat (PROG) @(negedge clk);
            check(sdo_oe && sdo, req, "ready shows high", int'({sdo_oe, sdo}), 3);
        end else begin
            check(!sdo_oe, req, "no cycle started", int'(sdo_oe), 0);
        end
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic o;
        rst = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0; org_wide = 1'b1;
        m_wel = 1'b0;
        for (int i = 0; i < 64; i++) ref16[i] = 'hFFFF;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        check(sdo_oe == 1'b0, "R8", "released after reset", int'(sdo_oe), 0);
        read_seq(1, 0, 1, 0, "R11");                      // erased after reset
        prog(1, 1, 5, 'hA5C3, "R6");                       // latch clear: ignored
        read_seq(1, 5, 1, 0, "R6");
        prog(1, 0, 'h30, 0, "R2");                         // enable
        prog(1, 1, 5, 'hA5C3, "R7");                       // write
        read_seq(1, 5, 1, 3, "R1");                        // leading zeros
        prog(1, 1, 63, 'h1357, "R7");
        prog(1, 1, 0, 'h2468, "R7");
        read_seq(1, 63, 2, 0, "R4");                       // wrap 63 -> 0
        prog(1, 1, 5, 'h0F0F, "R7");                       // overwrite, no erase
        read_seq(1, 4, 2, 0, "R4");
        prog(1, 3, 5, 0, "R2");                            // erase
        read_seq(1, 5, 1, 0, "R7");

        prog(0, 1, 11, 'h3C, "R10");
        prog(0, 1, 10, 'h96, "R10");
        read_seq(0, 10, 2, 0, "R10");
        read_seq(1, 5, 1, 0, "R10");
        read_seq(0, 127, 2, 0, "R4");                      // byte wrap
        prog(0, 3, 10, 0, "R10");                          // byte erase
        read_seq(1, 5, 1, 0, "R10");

        // R5: deselect in the middle of the data field
        org_wide = 1'b1;
        cs_on();
        send(1, 1, o); send(1, 2, o); send(7, 6, o); send('hC, 4, o);
        cs_off();
        cs_on();
        check(sdo_oe == 1'b0, "R5", "aborted frame starts no cycle", int'(sdo_oe), 0);
        cs_off();
        read_seq(1, 7, 1, 0, "R5");

        // R9: a full instruction during busy is ignored
        cs_on();
        send(1, 1, o); send(1, 2, o); send(20, 6, o); send('h1111, 16, o);
        cs_off();
        m_apply(1, 1, 0, 20, 'h1111);
        cs_on();
        check(sdo_oe && !sdo, "R9", "busy after first write", int'({sdo_oe, sdo}), 2);
        send(1, 1, o); send(1, 2, o); send(21, 6, o); send('h2222, 16, o);
        cs_off();
        cs_on();
        repeat (PROG) @(negedge clk);
        check(sdo_oe && sdo, "R9", "ready after cycle", int'({sdo_oe, sdo}), 3);
        cs_off();
        read_seq(1, 20, 2, 0, "R9");

        prog(1, 0, 'h20, 0, "R7");                         // erase-all
        read_seq(1, 0, 3, 0, "R7");
        prog(1, 0, 'h10, 'hBEEF, "R7");                    // write-all 16-bit
        read_seq(1, 62, 3, 0, "R7");
        prog(0, 0, 'h20, 'h5A, "R7");                      // write-all 8-bit
        read_seq(1, 9, 2, 0, "R7");
        prog(1, 0, 'h00, 0, "R6");                         // disable
        prog(1, 1, 1, 'h0000, "R6");                       // ignored
        read_seq(1, 1, 1, 0, "R3");                        // read with latch clear

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule